// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block gathers the interrupt conditions of an asynchronous serial port. It remembers each one as a pending flag and reports the most urgent enabled flag as a 4-bit identification code. It also drives a single interrupt request line. Five condition inputs feed it, each a one-cycle pulse from the surrounding port logic:
- a receive line error (overrun, parity, framing or break),
- received data ready (any data in single-buffer operation, or the FIFO trigger level reached),
- a receive character timeout,
- the transmit holding register becoming empty,
- a change on one of the modem control lines.

Bus strobes from the register decoder clear the flags. Each strobe marks a read of the line status, modem status, receive buffer or identification register, or a write to the transmit holding register. A five-bit enable vector masks sources from reporting. Baud generation, the shifters and the FIFOs sit outside this block.

The code is a pure function of the flags and enables, so the host sees a new code in the cycle after the event edge. It keeps seeing that code until the matching clear strobe has been taken at a clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no flag is pending, `irq_code_o` is 4'b0001 and `irq_o` is 0.
- R2: A pulse on a condition input sets that source's flag at the next rising clock edge. The flag then stays set until its own clear strobe is taken. Strobes that belong to other sources leave it untouched.
- R3: The reported code is that of the highest-priority enabled pending source, in this order: line error 4'b0110, then data ready 4'b0100, then character timeout 4'b1100, then transmit empty 4'b0010, then modem change 4'b0000. Data ready and timeout share level 2, and data ready wins between them.
- R4: `rd_lsr_i` clears the line error flag. `rd_rbr_i` clears both the data ready flag and the timeout flag. `rd_msr_i` clears the modem flag. `wr_thr_i` clears the transmit empty flag. Each clear takes effect at the clock edge on which the strobe is high.
- R5: `rd_iir_i` clears the transmit empty flag only when the code presented in that same cycle is 4'b0010. In any other cycle it has no effect on any flag.
- R6: If a source's condition pulse and its clear strobe (including a clearing identification read) arrive in the same cycle, the flag is set after that edge.
- R7: `src_en_i` bit 0 enables line error, bit 1 data ready, bit 2 timeout, bit 3 transmit empty and bit 4 modem change. A disabled source never appears in the code and never raises `irq_o`. Its flag is still recorded and is reported as soon as its enable bit is set.
- R8: `irq_o` is 1 exactly when bit 0 of `irq_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 5 | Per-source enables (bit map in R7) |
| ev_line_err_i | input | 1 | Receive line error pulse |
| ev_rx_avail_i | input | 1 | Received data ready pulse |
| ev_rx_tmo_i | input | 1 | Character timeout pulse |
| ev_thr_empty_i | input | 1 | Transmit holding register empty pulse |
| ev_modem_i | input | 1 | Modem line change pulse |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| irq_code_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets four risks.
- An identification read while a higher source hides the transmit empty flag. A design that ignores what was presented would lose that flag without the host ever seeing it.
- The level-2 tie between data ready and timeout. Reversing it would show 4'b1100 while data is waiting.
- A condition pulse and its clear strobe in the same cycle. A design where clear wins would drop a fresh event.
- A pending flag behind a disabled enable. A design that filters at capture would never report the flag once enabled. A design that filters only the code would still assert `irq_o`.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;

  // source index doubles as priority rank, 0 most urgent
  localparam int SRC_LINE  = 0;
  localparam int SRC_AVAIL = 1;
  localparam int SRC_TMO   = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;

  localparam int CODE_W = 4;
  localparam int IDX_W  = $clog2(NUM_SRC);

  localparam logic [CODE_W-1:0] CODE_NONE  = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_LINE  = 4'b0110;
  localparam logic [CODE_W-1:0] CODE_AVAIL = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_TMO   = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_THRE  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 4'b0000;

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(SRC_LINE):  return CODE_LINE;
      IDX_W'(SRC_AVAIL): return CODE_AVAIL;
      IDX_W'(SRC_TMO):   return CODE_TMO;
      IDX_W'(SRC_THRE):  return CODE_THRE;
      IDX_W'(SRC_MODEM): return CODE_MODEM;
      default:           return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // a new event outranks a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  a_r4_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] active_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               irq_o
);
  logic [IDX_W-1:0] win_idx;
  logic             any_act;

  always_comb begin
    win_idx = '0;
    any_act = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active_i[i]) begin
        win_idx = IDX_W'(i);
        any_act = 1'b1;
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (any_act) grant_o[win_idx] = 1'b1;
  end

  assign code_o = any_act ? src_code(win_idx) : CODE_NONE;
  assign irq_o  = |active_i;

  a_r3_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r3_line_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i[SRC_LINE] |-> code_o == CODE_LINE);
  a_r3_avail_over_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i[SRC_AVAIL] && !active_i[SRC_LINE]) |-> code_o == CODE_AVAIL);
  a_r8_irq_vs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !code_o[0]);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        src_en_i,
  input  logic              ev_line_err_i,
  input  logic              ev_rx_avail_i,
  input  logic              ev_rx_tmo_i,
  input  logic              ev_thr_empty_i,
  input  logic              ev_modem_i,
  input  logic              rd_iir_i,
  input  logic              rd_lsr_i,
  input  logic              rd_msr_i,
  input  logic              rd_rbr_i,
  input  logic              wr_thr_i,
  output logic [CODE_W-1:0] irq_code_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] set_vec, clr_vec, pend_vec, active, grant;

  assign set_vec[SRC_LINE]  = ev_line_err_i;
  assign set_vec[SRC_AVAIL] = ev_rx_avail_i;
  assign set_vec[SRC_TMO]   = ev_rx_tmo_i;
  assign set_vec[SRC_THRE]  = ev_thr_empty_i;
  assign set_vec[SRC_MODEM] = ev_modem_i;

  // identification read only retires transmit-empty when it was the one shown
  assign clr_vec[SRC_LINE]  = rd_lsr_i;
  assign clr_vec[SRC_AVAIL] = rd_rbr_i;
  assign clr_vec[SRC_TMO]   = rd_rbr_i;
  assign clr_vec[SRC_THRE]  = wr_thr_i | (rd_iir_i & grant[SRC_THRE]);
  assign clr_vec[SRC_MODEM] = rd_msr_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    uart_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend_vec[g])
    );
  end

  assign active = pend_vec & src_en_i;

  uart_irq_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .grant_o  (grant),
    .code_o   (irq_code_o),
    .irq_o    (irq_o)
  );

  a_r7_thre_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_en_i[SRC_THRE] |-> irq_code_o != CODE_THRE);
  a_r7_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_i == '0) |-> !irq_o);
  a_r5_iir_retires_thre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iir_i && irq_code_o == CODE_THRE && !ev_thr_empty_i) |=> !pend_vec[SRC_THRE]);
  a_r5_iir_spares_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iir_i && irq_code_o != CODE_THRE && pend_vec[SRC_THRE] && !wr_thr_i)
      |=> pend_vec[SRC_THRE]);
endmodule

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] src_en_i = '0;
  logic       ev_line_err_i = 0, ev_rx_avail_i = 0, ev_rx_tmo_i = 0;
  logic       ev_thr_empty_i = 0, ev_modem_i = 0;
  logic       rd_iir_i = 0, rd_lsr_i = 0, rd_msr_i = 0, rd_rbr_i = 0, wr_thr_i = 0;
  logic [3:0] irq_code_o;
  logic       irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int m_pend[5];

  always #10 clk_i = ~clk_i;

  uart_irq_ident dut_i (.*);

  function automatic logic [3:0] model_code();
    if (m_pend[0] != 0 && src_en_i[0]) return 4'b0110;
    if (m_pend[1] != 0 && src_en_i[1]) return 4'b0100;
    if (m_pend[2] != 0 && src_en_i[2]) return 4'b1100;
    if (m_pend[3] != 0 && src_en_i[3]) return 4'b0010;
    if (m_pend[4] != 0 && src_en_i[4]) return 4'b0000;
    return 4'b0001;
  endfunction

  // reference model: flags as integers, updated on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 5; i++) m_pend[i] = 0;
    end else begin
      logic thre_shown;
      thre_shown = (model_code() == 4'b0010);
      if (rd_lsr_i) m_pend[0] = 0;
      if (rd_rbr_i) begin m_pend[1] = 0; m_pend[2] = 0; end
      if (wr_thr_i || (rd_iir_i && thre_shown)) m_pend[3] = 0;
      if (rd_msr_i) m_pend[4] = 0;
      if (ev_line_err_i)  m_pend[0] = 1;
      if (ev_rx_avail_i)  m_pend[1] = 1;
      if (ev_rx_tmo_i)    m_pend[2] = 1;
      if (ev_thr_empty_i) m_pend[3] = 1;
      if (ev_modem_i)     m_pend[4] = 1;
    end
  end

  task automatic compare();
    logic [3:0] exp_c;
    exp_c = model_code();
    checks++;
    if (irq_code_o !== exp_c) begin
      fails++;
      $display("FAIL %s code act=%b exp=%b t=%0t", cur_req, irq_code_o, exp_c, $time);
    end
    checks++;
    if (irq_o !== (exp_c[0] == 1'b0)) begin
      fails++;
      $display("FAIL %s irq act=%b exp=%b t=%0t", cur_req, irq_o, !exp_c[0], $time);
    end
    checks++;
    if (irq_o !== !irq_code_o[0]) begin  // R8
      fails++;
      $display("FAIL R8 irq act=%b exp=%b t=%0t", irq_o, !irq_code_o[0], $time);
    end
  endtask

  task automatic clear_in();
    {ev_line_err_i, ev_rx_avail_i, ev_rx_tmo_i, ev_thr_empty_i, ev_modem_i} = '0;
    {rd_iir_i, rd_lsr_i, rd_msr_i, rd_rbr_i, wr_thr_i} = '0;
  endtask

  // inputs applied after the falling edge, outputs checked before the next one
  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    clear_in();
    #1 compare();
  endtask

  task automatic expect_code(input logic [3:0] c, input string req);
    checks++;
    if (irq_code_o !== c) begin
      fails++;
      $display("FAIL %s directed code act=%b exp=%b", req, irq_code_o, c);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    #35 ;
    cur_req = "R1";
    compare();
    expect_code(4'b0001, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    src_en_i = 5'b11111;
    #1 compare();

    // R2: modem event held across unrelated strobes
    cur_req = "R2";
    ev_modem_i = 1; cyc();
    expect_code(4'b0000, "R2");
    rd_lsr_i = 1; rd_rbr_i = 1; wr_thr_i = 1; rd_iir_i = 1; cyc();
    expect_code(4'b0000, "R2");
    cur_req = "R4";
    rd_msr_i = 1; cyc();
    expect_code(4'b0001, "R4");

    // R3: full priority ladder
    cur_req = "R3";
    ev_line_err_i = 1; ev_rx_avail_i = 1; ev_rx_tmo_i = 1; ev_thr_empty_i = 1; ev_modem_i = 1;
    cyc(); expect_code(4'b0110, "R3");
    rd_lsr_i = 1; cyc(); expect_code(4'b0100, "R3");
    // R5: identification read while transmit empty is hidden
    cur_req = "R5";
    rd_iir_i = 1; cyc(); expect_code(4'b0100, "R5");
    cur_req = "R4";
    rd_rbr_i = 1; cyc(); expect_code(4'b0010, "R4");
    cur_req = "R5";
    rd_iir_i = 1; cyc(); expect_code(4'b0000, "R5");
    cur_req = "R4";
    rd_msr_i = 1; cyc(); expect_code(4'b0001, "R4");

    // R3: timeout alone, then data ready joins
    cur_req = "R3";
    ev_rx_tmo_i = 1; cyc(); expect_code(4'b1100, "R3");
    ev_rx_avail_i = 1; cyc(); expect_code(4'b0100, "R3");
    rd_rbr_i = 1; cyc(); expect_code(4'b0001, "R4");

    // R6: event and clear together
    cur_req = "R6";
    ev_thr_empty_i = 1; cyc();
    ev_thr_empty_i = 1; rd_iir_i = 1; cyc(); expect_code(4'b0010, "R6");
    ev_thr_empty_i = 1; wr_thr_i = 1; cyc(); expect_code(4'b0010, "R6");
    ev_line_err_i = 1; rd_lsr_i = 1; cyc(); expect_code(4'b0110, "R6");
    rd_lsr_i = 1; wr_thr_i = 1; cyc(); expect_code(4'b0001, "R6");

    // R7: masked source remembered
    cur_req = "R7";
    src_en_i = 5'b10111;
    ev_thr_empty_i = 1; cyc(); expect_code(4'b0001, "R7");
    checks++;
    if (irq_o !== 1'b0) begin fails++; $display("FAIL R7 irq act=%b exp=0", irq_o); end
    rd_iir_i = 1; cyc();
    src_en_i = 5'b11111; #1 compare(); expect_code(4'b0010, "R7");
    wr_thr_i = 1; cyc();
    src_en_i = 5'b00000;
    ev_line_err_i = 1; ev_modem_i = 1; cyc(); expect_code(4'b0001, "R7");
    src_en_i = 5'b10000; #1 compare(); expect_code(4'b0000, "R7");
    rd_lsr_i = 1; rd_msr_i = 1; cyc();
    src_en_i = 5'b11111; #1 compare();

    // random traffic against the model
    cur_req = "R3";
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      {ev_line_err_i, ev_rx_avail_i, ev_rx_tmo_i, ev_thr_empty_i, ev_modem_i} = 5'($urandom) & 5'($urandom);
      {rd_iir_i, rd_lsr_i, rd_msr_i, rd_rbr_i, wr_thr_i} = 5'($urandom) & 5'($urandom);
      if (($urandom % 16) == 0) src_en_i = 5'($urandom);
      #1 compare();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule